// File: doc/BRIEF.md
# Packet-Aware Receive Byte FIFO

This block buffers bytes coming out of a bit-level frame decoder until a host fetches them. Each incoming byte comes with two markers, one for the first byte of a packet and one for the last. Each byte the host reads comes back with a two-bit tag. The tag says whether the byte is an ordinary packet byte, the closing byte of a packet, or the last surviving byte of a packet that was cut short. A separate strobe marks a read that found nothing to return.

The host sets a data-available threshold. The block drives a live flag while more bytes are stored than that threshold. On overflow the block either refuses the byte or marks the packet in progress as aborted, and it raises a one-cycle event strobe for an outside status latch. It then ignores the input stream until a fresh packet begins while enough room is free.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the store is empty, `data_avail` and `ovf_pulse` are low, the discard state is clear, and the first packet-start byte written is accepted.
- R2: Accepted bytes are read back in write order. Each byte carries the tag 0 (ordinary byte), or the tag 1 when it was written with `wr_eop` high.
- R3: `data_avail` is high exactly while the number of stored bytes is strictly greater than `watermark`. It follows a change of `watermark` in the same cycle.
- R4: A read of an empty store changes no state. It returns `rd_invalid` high and `rd_valid` low, and the next accepted byte is still the next byte read.
- R5: A packet-start byte written while the store is full is discarded and raises `ovf_pulse`. No stored tag changes.
- R6: A byte without the start marker, written while the store is full inside a packet, raises `ovf_pulse`. It sets the tag of the most recently stored byte to 2 (abort), and the byte itself is discarded.
- R7: After an overflow, every written byte is discarded until a packet-start byte arrives while at least `RESYNC_FREE` slots are free. That byte is stored.
- R8: `ovf_pulse` is high for one cycle per overflow, in the cycle after the offending write. Bytes discarded during the discard state raise no pulse.
- R9: A read issued at a clock edge presents `rd_valid` or `rd_invalid`, together with `rd_data` and `rd_tag`, for the one cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte offered by the frame decoder |
| wr_sop | input | 1 | Offered byte starts a packet |
| wr_eop | input | 1 | Offered byte ends a packet |
| wr_data | input | DATA_W | Offered byte |
| rd_en | input | 1 | Host read request |
| watermark | input | $clog2(DEPTH)+1 | Data-available threshold |
| rd_valid | output | 1 | Read returned a stored byte |
| rd_invalid | output | 1 | Read found the store empty |
| rd_data | output | DATA_W | Byte returned by a read |
| rd_tag | output | 2 | 0 ordinary, 1 packet end, 2 abort |
| data_avail | output | 1 | Stored count exceeds the watermark |
| ovf_pulse | output | 1 | One-cycle overflow event |

## Verification
The hardest state to reach is resynchronisation at its exact room limit. The store must be full, then overflow, then be drained to one slot short of the required free space. A start byte offered at that point must be refused with no new overflow strobe. After one more read, a start byte must be accepted. The bench fills the store, forces an overflow with a non-start byte, and reads a counted number of entries. It offers start bytes on each side of the limit. It then drains the store and checks the abort tag on the last surviving byte and the position of the accepted packet behind it.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;
   typedef enum logic [1:0] {
      TAG_NORMAL = 2'd0,
      TAG_END    = 2'd1,
      TAG_ABORT  = 2'd2
   } tag_e;
endpackage

// File: rtl/pkt_rx_level.sv
module pkt_rx_level #(
   parameter int DEPTH       = 256,
   parameter int RESYNC_FREE = 16,
   parameter bit FLAG_REG    = 1'b0,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          rd_en,
   input  logic [LW-1:0] watermark,
   output logic          pop,
   output logic          full,
   output logic          room_ok,
   output logic          data_avail
);
   localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
   localparam logic [LW-1:0] ROOM_LIM = LW'(DEPTH - RESYNC_FREE);

   logic [LW-1:0] count_q, count_d;

   assign pop     = rd_en && (count_q != '0);
   assign full    = (count_q == FULL_CNT);
   assign room_ok = (count_q <= ROOM_LIM);

   always_comb begin
      count_d = count_q;
      if (push && !pop)      count_d = count_q + 1'b1;
      else if (!push && pop) count_d = count_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end

   generate
      if (FLAG_REG) begin : g_flag_reg
         logic da_q;
         always_ff @(posedge clk) begin
            if (!rst_n) da_q <= 1'b0;
            else        da_q <= (count_d > watermark);
         end
         assign data_avail = da_q;
      end else begin : g_flag_comb
         assign data_avail = (count_q > watermark);
      end
   endgenerate

   a_r2_no_push_full : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r3_flag_low_empty : assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0) |-> !data_avail);
   a_r2_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);
endmodule

// File: rtl/pkt_rx_admit.sv
module pkt_rx_admit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_sop,
   input  logic wr_eop,
   input  logic full,
   input  logic room_ok,
   output logic push,
   output logic abort_mark,
   output logic ovf_set
);
   logic drop_q, drop_d;
   logic in_pkt_q, in_pkt_d;

   always_comb begin
      push       = 1'b0;
      abort_mark = 1'b0;
      ovf_set    = 1'b0;
      drop_d     = drop_q;
      in_pkt_d   = in_pkt_q;
      if (wr_en) begin
         if (drop_q) begin
            if (wr_sop && room_ok && !full) begin
               push   = 1'b1;
               drop_d = 1'b0;
            end
         end else if (full) begin
            ovf_set    = 1'b1;
            drop_d     = 1'b1;
            abort_mark = !wr_sop && in_pkt_q;
            in_pkt_d   = 1'b0;
         end else begin
            push = 1'b1;
         end
      end
      if (push) begin
         if (wr_sop) in_pkt_d = 1'b1;
         if (wr_eop) in_pkt_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_q   <= 1'b0;
         in_pkt_q <= 1'b0;
      end else begin
         drop_q   <= drop_d;
         in_pkt_q <= in_pkt_d;
      end
   end

   a_r7_drop_after_ovf : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> drop_q);
   a_r6_abort_only_full : assert property (@(posedge clk) disable iff (!rst_n)
      abort_mark |-> (full && wr_en));
endmodule

// File: rtl/pkt_rx_store.sv
module pkt_rx_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        wr_tag,
   input  logic              abort_mark,
   input  logic              rd_en,
   input  logic              pop,
   output logic              rd_valid,
   output logic              rd_invalid,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_tag
);
   import pkt_rx_fifo_pkg::*;

   logic [DATA_W-1:0] data_mem [DEPTH];
   logic [1:0]        tag_mem  [DEPTH];
   logic [AW-1:0]     wr_ptr_q, rd_ptr_q, last_ptr;

   assign last_ptr = wr_ptr_q - 1'b1;

   always_ff @(posedge clk) begin
      if (push) begin
         data_mem[wr_ptr_q] <= wr_data;
         tag_mem[wr_ptr_q]  <= wr_tag;
      end else if (abort_mark) begin
         tag_mem[last_ptr] <= TAG_ABORT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q   <= '0;
         rd_ptr_q   <= '0;
         rd_valid   <= 1'b0;
         rd_invalid <= 1'b0;
         rd_data    <= '0;
         rd_tag     <= TAG_NORMAL;
      end else begin
         rd_valid   <= pop;
         rd_invalid <= rd_en && !pop;
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop) begin
            rd_data  <= data_mem[rd_ptr_q];
            rd_tag   <= tag_mem[rd_ptr_q];
            rd_ptr_q <= rd_ptr_q + 1'b1;
         end
      end
   end

   a_r4_rd_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && rd_invalid));
   a_r9_rd_response : assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_valid || rd_invalid));
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
   parameter int DEPTH       = 256,
   parameter int DATA_W      = 8,
   parameter int RESYNC_FREE = 16,
   parameter bit FLAG_REG    = 1'b0,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [LW-1:0]     watermark,
   output logic              rd_valid,
   output logic              rd_invalid,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_tag,
   output logic              data_avail,
   output logic              ovf_pulse
);
   import pkt_rx_fifo_pkg::*;

   initial begin
      assert ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 2)
         else $error("DEPTH must be a power of two of at least 2");
      assert (RESYNC_FREE >= 1 && RESYNC_FREE <= DEPTH)
         else $error("RESYNC_FREE must lie in 1..DEPTH");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic push, pop, full, room_ok, abort_mark, ovf_set, ovf_q;
   logic [1:0] wr_tag;

   assign wr_tag = wr_eop ? TAG_END : TAG_NORMAL;

   pkt_rx_admit u_admit (
      .clk, .rst_n, .wr_en, .wr_sop, .wr_eop, .full, .room_ok,
      .push, .abort_mark, .ovf_set
   );

   pkt_rx_level #(.DEPTH(DEPTH), .RESYNC_FREE(RESYNC_FREE), .FLAG_REG(FLAG_REG)) u_level (
      .clk, .rst_n, .push, .rd_en, .watermark,
      .pop, .full, .room_ok, .data_avail
   );

   pkt_rx_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk, .rst_n, .push, .wr_data, .wr_tag, .abort_mark, .rd_en, .pop,
      .rd_valid, .rd_invalid, .rd_data, .rd_tag
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= ovf_set;
   end
   assign ovf_pulse = ovf_q;

   a_r8_ovf_single : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);
   a_r5_ovf_needs_write : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> $past(wr_en));
   a_r9_tag_legal : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_tag != 2'd3));
endmodule

// File: tb/test_pkt_rx_fifo.sv
module test_pkt_rx_fifo;
   localparam int DEPTH = 32;
   localparam int LW    = $clog2(DEPTH) + 1;
   localparam int VW    = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [LW-1:0] watermark = LW'(2);
   logic rd_valid, rd_invalid, data_avail, ovf_pulse;
   logic [7:0] rd_data;
   logic [1:0] rd_tag;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pkt_rx_fifo #(.DEPTH(DEPTH), .DATA_W(8), .RESYNC_FREE(16)) i_pkt_rx_fifo (
      .clk, .rst_n, .wr_en, .wr_sop, .wr_eop, .wr_data, .rd_en, .watermark,
      .rd_valid, .rd_invalid, .rd_data, .rd_tag, .data_avail, .ovf_pulse
   );

   // we sop eop data re | valid invalid data tag data_avail
   localparam logic [VW-1:0] VEC [10] = '{
      {3'b000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0},
      {3'b110, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
      {3'b100, 8'hA2, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0},
      {3'b101, 8'hA3, 1'b0, 1'b0, 1'b0, 8'h00, 2'd0, 1'b1},
      {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA1, 2'd0, 1'b0},
      {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA2, 2'd0, 1'b0},
      {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA3, 2'd1, 1'b0},
      {3'b000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0},
      {3'b111, 8'h5C, 1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 1'b0},
      {3'b000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h5C, 2'd1, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic wr(input bit sop, input bit eop, input logic [7:0] d);
      wr_en = 1'b1; wr_sop = sop; wr_eop = eop; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
   endtask

   task automatic rd();
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic fill(input int n);
      for (int i = 0; i < n; i++) wr(i == 0, 1'b0, 8'(i));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!data_avail && !ovf_pulse && !rd_valid && !rd_invalid, "R1 reset outputs",
          {data_avail, ovf_pulse, rd_valid, rd_invalid}, 0);

      // R2 R3 R4 R9 vector table
      for (int v = 0; v < 10; v++) begin
         logic [VW-1:0] e;
         logic [13:0] act, exp;
         e = VEC[v];
         {wr_en, wr_sop, wr_eop} = e[24:22];
         wr_data = e[21:14];
         rd_en   = e[13];
         @(posedge clk); @(negedge clk);
         wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; rd_en = 1'b0;
         exp = {e[12], e[11], e[12] ? e[10:3] : 8'h00, e[12] ? e[2:1] : 2'd0, e[0], 1'b0};
         act = {rd_valid, rd_invalid, e[12] ? rd_data : 8'h00, e[12] ? rd_tag : 2'd0,
                data_avail, ovf_pulse};
         chk(act == exp, $sformatf("R2 R3 R4 R9 vector %0d", v), act, exp);
      end

      // R6 abort tagging on overflow inside a packet
      fill(DEPTH);
      wr(1'b0, 1'b0, 8'hF0);
      chk(ovf_pulse, "R6 overflow pulse", ovf_pulse, 1);
      @(negedge clk);
      chk(!ovf_pulse, "R8 pulse one cycle", ovf_pulse, 0);

      // R7 partial drain leaves too little room
      bad = 0;
      for (int i = 0; i < 15; i++) begin
         rd();
         if (!rd_valid || rd_data != 8'(i) || rd_tag != 2'd0) bad++;
      end
      chk(bad == 0, "R2 first 15 after overflow", bad, 0);
      wr(1'b1, 1'b0, 8'h77);
      chk(!ovf_pulse, "R8 no pulse while discarding", ovf_pulse, 0);
      rd();
      chk(rd_valid && rd_data == 8'd15, "R7 byte 15", rd_data, 15);
      wr(1'b1, 1'b1, 8'hEE);
      bad = 0;
      for (int i = 16; i < DEPTH; i++) begin
         rd();
         if (!rd_valid || rd_data != 8'(i) || rd_tag != ((i == DEPTH - 1) ? 2'd2 : 2'd0)) bad++;
      end
      chk(bad == 0, "R6 remaining bytes, last tagged abort", bad, 0);
      rd();
      chk(rd_valid && rd_data == 8'hEE && rd_tag == 2'd1, "R7 resync packet accepted",
          {rd_valid, rd_data, rd_tag}, {1'b1, 8'hEE, 2'd1});
      rd();
      chk(rd_invalid && !rd_valid, "R4 R6 dropped bytes absent", {rd_valid, rd_invalid}, 1);

      // R5 packet start while full
      fill(DEPTH);
      wr(1'b1, 1'b0, 8'h99);
      chk(ovf_pulse, "R5 overflow pulse on start", ovf_pulse, 1);
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         rd();
         if (!rd_valid || rd_data != 8'(i) || rd_tag != 2'd0) bad++;
      end
      chk(bad == 0, "R5 tags untouched", bad, 0);
      wr(1'b0, 1'b0, 8'h31);
      rd();
      chk(rd_invalid, "R7 non-start byte discarded", rd_invalid, 1);

      // R1 reset clears discard state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(!data_avail, "R1 flag low after reset", data_avail, 0);
      wr(1'b1, 1'b1, 8'h42);
      rd();
      chk(rd_valid && rd_data == 8'h42 && rd_tag == 2'd1, "R1 first start accepted",
          rd_data, 8'h42);

      // R3 watermark follows at once
      watermark = '0;
      wr(1'b1, 1'b0, 8'h11);
      chk(data_avail, "R3 one byte above zero watermark", data_avail, 1);
      watermark = LW'(1);
      #1;
      chk(!data_avail, "R3 level equal to watermark", data_avail, 0);
      rd();
      chk(rd_valid && rd_data == 8'h11, "R2 byte after watermark test", rd_data, 8'h11);

      done = 1'b1;
      finish_run();
   end
endmodule